// File: doc/BRIEF.md
# Parallel Turbo Window and Iteration Scheduler

This block sequences a turbo decoder whose trellis work is shared by four soft-in soft-out engines running side by side. When a code block length and an iteration limit are presented with a start request, it splits the block into four equal segments and reports each segment's base address. It then steps through half-iterations, each with a fixed cycle budget. Within a half-iteration it raises a strobe at the start of every 64-step sliding window and reports the index of the current window.

Half-iterations alternate between natural order (even) and interleaved order (odd). After every full iteration the scheduler either stops or continues. It stops when the early-termination input is high at the end of that iteration, or when the iteration limit has been reached. It then pulses a done flag. The iteration count and the total cycle count of the decode stay on the outputs until the next decode begins, so that throughput can be checked. The engine arithmetic and the interleaver address generation sit outside this block.

Top module: `turbo_win_sched`

## Requirements
- R1: After reset, every output is zero: not busy, no done pulse, no window strobe, window index 0, half-iteration 0, phase 0, iteration count 0, cycle count 0 and all segment bases 0.
- R2: A start request is taken only while the scheduler is idle and only when the length is between 1 and 6144 and a multiple of 8. Any other request changes no output: busy stays low when idle, and the segment bases stay unchanged when busy.
- R3: For an accepted block length S, segment base k (bits k*13 to k*13+12 of the base bus) equals k*S/4 for k = 0 to 3, and holds until the next accepted start.
- R4: Every half-iteration lasts exactly S/8 + 64 + 10 cycles. Two trellis steps are handled per cycle on a quarter of the block, plus one window of warm-up, plus 10 overhead cycles.
- R5: Within a half-iteration, the window strobe is high in the cycles at offsets 0, 32, 64 and onward, for exactly ceil((S/4)/64) windows. The window index equals the offset divided by 32, saturated at the last window, and is 0 when idle.
- R6: The half-iteration index counts from 0 in each decode. The phase output is 0 (natural order) on even half-iterations and 1 (interleaved order) on odd ones.
- R7: The early-termination input is sampled only in the last cycle of an odd half-iteration. If it is high then, decoding ends after that iteration. At any other cycle it has no effect.
- R8: Decoding ends after the iteration limit is reached. A limit of 0 acts as 1, and a limit above 8 acts as 8.
- R9: The done flag is high for exactly one cycle, the first idle cycle after the decode. The iteration count then gives the number of full iterations completed and holds until the next accepted start.
- R10: The cycle counter is cleared by an accepted start and counts every busy cycle. After a decode it holds the total, which equals 2 × iterations × (S/8 + 74).
- R11: A start request presented in the same cycle as the done pulse is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request for a new block |
| blk_len_i | input | 13 | Code block length in bits |
| iter_lim_i | input | 4 | Maximum number of full iterations |
| early_stop_i | input | 1 | Early-termination condition from the decoder |
| busy_o | output | 1 | Decode in progress |
| done_o | output | 1 | One-cycle pulse after the decode ends |
| seg_base_o | output | 52 | Four 13-bit segment base addresses, segment k in bits k*13 upward |
| win_start_o | output | 1 | Strobe at the start of a sliding window |
| win_idx_o | output | 5 | Current window index within the half-iteration |
| half_idx_o | output | 4 | Current half-iteration index |
| phase_o | output | 1 | 0 natural order, 1 interleaved order |
| iters_o | output | 4 | Full iterations completed |
| cycle_cnt_o | output | 14 | Busy cycles since the accepted start |

## Verification
Two events can fall on the same cycle. One is the last cycle of an odd half-iteration, where the early-termination input and the iteration limit both decide the stop. The other is the done pulse, in which a new start may arrive. The bench drives the early-termination input in patterns locked to its own model state: always high, high only during even half-iterations, or high only in the final cycle of the second iteration. It also issues a start exactly in the done cycle. Every cycle it compares all outputs against a behavioural model. At each done pulse it also checks the iteration count and the closed-form cycle total.

// File: rtl/tsch_pkg.sv
// Shared types for the turbo window/iteration scheduler.
// Assumes: nothing beyond a two-state control flow.
package tsch_pkg;
    typedef enum logic {
        SCH_IDLE = 1'b0,
        SCH_RUN  = 1'b1
    } sch_state_e;
endpackage

// File: rtl/tsch_cfg.sv
// Segment configuration: captures the per-engine segment length on an
// accepted start and derives the half-iteration cycle budget, the window
// count and the segment base addresses from it.
// Assumes: N_SISO and WIN are powers of two; the caller checks the length.
module tsch_cfg #(
    parameter int N_SISO = 4,
    parameter int WIN    = 64,
    parameter int OVH    = 10,
    parameter int LEN_W  = 13,
    parameter int SEG_W  = 11,
    parameter int BUD_W  = 10,
    parameter int NW_W   = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load_i,
    input  logic [LEN_W-1:0]          blk_len_i,
    output logic [BUD_W-1:0]          budget_o,
    output logic [NW_W-1:0]           nwin_o,
    output logic [N_SISO*LEN_W-1:0]   seg_base_o
);
    localparam int SISO_SH = $clog2(N_SISO);
    localparam int WIN_SH  = $clog2(WIN);

    logic [SEG_W-1:0] seg_q;
    logic [SEG_W:0]   seg_rnd;

    // Capture the quarter-block length when a decode is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seg_q <= '0;
        else if (load_i)
            seg_q <= SEG_W'(blk_len_i >> SISO_SH);
    end

    // Half-iteration budget: two steps per cycle, one warm-up window, overhead.
    assign budget_o = BUD_W'(seg_q >> 1) + BUD_W'(WIN + OVH);

    // Windows per segment, rounded up.
    assign seg_rnd = {1'b0, seg_q} + (SEG_W + 1)'(WIN - 1);
    assign nwin_o  = NW_W'(seg_rnd >> WIN_SH);

    // One base address per engine.
    for (genvar k = 0; k < N_SISO; k++) begin : g_base
        assign seg_base_o[k*LEN_W +: LEN_W] = LEN_W'(k) * LEN_W'(seg_q);
    end
endmodule

// File: rtl/tsch_half_timer.sv
// Half-iteration timer: counts cycles within a half-iteration, flags its last
// cycle and decodes window strobes every WIN/2 cycles (radix-4 timing).
// Assumes: WIN is a power of two of at least 4; budget_i is at least 1 while run_i.
module tsch_half_timer #(
    parameter int WIN   = 64,
    parameter int HC_W  = 10,
    parameter int BUD_W = 10,
    parameter int NW_W  = 5,
    parameter int WI_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [BUD_W-1:0]  budget_i,
    input  logic [NW_W-1:0]   nwin_i,
    output logic              half_end_o,
    output logic              win_start_o,
    output logic [WI_W-1:0]   win_idx_o
);
    localparam int STEP_SH = $clog2(WIN) - 1;

    logic [HC_W-1:0]         hc_q;
    logic [HC_W-STEP_SH-1:0] slot;

    assign slot       = hc_q[HC_W-1:STEP_SH];
    assign half_end_o = run_i && (BUD_W'(hc_q) == budget_i - BUD_W'(1));

    // Cycle-in-half counter, restarted at every half-iteration boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hc_q <= '0;
        else if (run_i && !half_end_o)
            hc_q <= hc_q + HC_W'(1);
        else
            hc_q <= '0;
    end

    // Strobe on each window boundary while windows remain.
    always_comb begin
        win_start_o = run_i && (hc_q[STEP_SH-1:0] == '0) && (int'(slot) < int'(nwin_i));
    end

    // Window index, saturated at the last window, zero when idle.
    always_comb begin
        if (!run_i)
            win_idx_o = '0;
        else if (int'(slot) >= int'(nwin_i))
            win_idx_o = WI_W'(nwin_i - NW_W'(1));
        else
            win_idx_o = WI_W'(slot);
    end

    // R4: the counter never reaches the budget
    p_hc_in_budget_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (BUD_W'(hc_q) < budget_i));

    // R5: strobes are WIN/2 cycles apart, never back to back
    p_window_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        win_start_o |=> !win_start_o);
endmodule

// File: rtl/tsch_iter_ctrl.sv
// Iteration controller: idle/run state, half-iteration and iteration
// counting, early-stop and limit decision, done pulse and cycle counter.
// Assumes: lim_i is already clamped to 1..MAX_ITER; half_end_i only while running.
module tsch_iter_ctrl #(
    parameter int MAX_ITER = 8,
    parameter int IT_W     = 4,
    parameter int HF_W     = 4,
    parameter int CYC_W    = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_ok_i,
    input  logic [IT_W-1:0]   lim_i,
    input  logic              half_end_i,
    input  logic              early_stop_i,
    output logic              run_o,
    output logic              done_o,
    output logic [HF_W-1:0]   half_o,
    output logic [IT_W-1:0]   iters_o,
    output logic [CYC_W-1:0]  cyc_o
);
    import tsch_pkg::*;

    sch_state_e       st_q;
    logic [IT_W-1:0]  lim_q;
    logic [IT_W-1:0]  iters_q;
    logic [HF_W-1:0]  half_q;
    logic [CYC_W-1:0] cyc_q;
    logic             done_q;
    logic             iter_end;
    logic             finish;

    assign iter_end = half_end_i && half_q[0];
    assign finish   = iter_end && (early_stop_i || (iters_q + IT_W'(1) == lim_q));

    // State and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SCH_IDLE;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (st_q == SCH_IDLE && start_ok_i)
                st_q <= SCH_RUN;
            else if (st_q == SCH_RUN && finish) begin
                st_q   <= SCH_IDLE;
                done_q <= 1'b1;
            end
        end
    end

    // Half-iteration, iteration, limit and cycle bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_q   <= IT_W'(1);
            iters_q <= '0;
            half_q  <= '0;
            cyc_q   <= '0;
        end else if (st_q == SCH_IDLE) begin
            if (start_ok_i) begin
                lim_q   <= lim_i;
                iters_q <= '0;
                half_q  <= '0;
                cyc_q   <= '0;
            end
        end else begin
            cyc_q <= cyc_q + CYC_W'(1);
            if (iter_end)
                iters_q <= iters_q + IT_W'(1);
            if (finish)
                half_q <= '0;
            else if (half_end_i)
                half_q <= half_q + HF_W'(1);
        end
    end

    assign run_o   = (st_q == SCH_RUN);
    assign done_o  = done_q;
    assign half_o  = half_q;
    assign iters_o = iters_q;
    assign cyc_o   = cyc_q;

    // R9: done lasts a single cycle
    p_done_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R7: a decode only ends on the last cycle of an odd half-iteration
    p_stop_on_odd_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SCH_IDLE && $past(st_q) == SCH_RUN) |-> $past(half_q[0]) && $past(half_end_i));

    // R8: half-iteration index stays within twice the limit
    p_half_in_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        run_o |-> (int'(half_q) < 2 * int'(lim_q)) && (int'(lim_q) >= 1) && (int'(lim_q) <= MAX_ITER));
endmodule

// File: rtl/turbo_win_sched.sv
// Top of the parallel turbo window/iteration scheduler: validates start
// requests, clamps the iteration limit and ties configuration, half-iteration
// timer and iteration controller together.
// Assumes: one code block at a time; engine arithmetic lives elsewhere.
module turbo_win_sched #(
    parameter int N_SISO   = 4,
    parameter int WIN      = 64,
    parameter int OVH      = 10,
    parameter int MAX_BLK  = 6144,
    parameter int MAX_ITER = 8,
    localparam int LEN_W    = $clog2(MAX_BLK + 1),
    localparam int SEG_W    = $clog2(MAX_BLK / N_SISO + 1),
    localparam int MAX_BUD  = MAX_BLK / (2 * N_SISO) + WIN + OVH,
    localparam int HC_W     = $clog2(MAX_BUD),
    localparam int BUD_W    = $clog2(MAX_BUD + 1),
    localparam int MAX_NWIN = (MAX_BLK / N_SISO + WIN - 1) / WIN,
    localparam int NW_W     = $clog2(MAX_NWIN + 1),
    localparam int WI_W     = $clog2(MAX_NWIN),
    localparam int IT_W     = $clog2(MAX_ITER + 1),
    localparam int HF_W     = $clog2(2 * MAX_ITER),
    localparam int CYC_W    = $clog2(2 * MAX_ITER * MAX_BUD + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [LEN_W-1:0]         blk_len_i,
    input  logic [IT_W-1:0]          iter_lim_i,
    input  logic                     early_stop_i,
    output logic                     busy_o,
    output logic                     done_o,
    output logic [N_SISO*LEN_W-1:0]  seg_base_o,
    output logic                     win_start_o,
    output logic [WI_W-1:0]          win_idx_o,
    output logic [HF_W-1:0]          half_idx_o,
    output logic                     phase_o,
    output logic [IT_W-1:0]          iters_o,
    output logic [CYC_W-1:0]         cycle_cnt_o
);
    localparam logic [LEN_W-1:0] LEN_MASK = LEN_W'(2 * N_SISO - 1);

    logic             len_ok;
    logic             start_ok;
    logic [IT_W-1:0]  lim_eff;
    logic [BUD_W-1:0] budget;
    logic [NW_W-1:0]  nwin;
    logic             run;
    logic             half_end;

    // Accept only idle starts with a legal, segment-aligned length.
    always_comb begin
        len_ok   = (blk_len_i != '0) && (int'(blk_len_i) <= MAX_BLK)
                   && ((blk_len_i & LEN_MASK) == '0);
        start_ok = start_i && !run && len_ok;
    end

    // Clamp the iteration limit into 1..MAX_ITER.
    always_comb begin
        if (iter_lim_i == '0)
            lim_eff = IT_W'(1);
        else if (int'(iter_lim_i) > MAX_ITER)
            lim_eff = IT_W'(MAX_ITER);
        else
            lim_eff = iter_lim_i;
    end

    tsch_cfg #(
        .N_SISO(N_SISO), .WIN(WIN), .OVH(OVH),
        .LEN_W(LEN_W), .SEG_W(SEG_W), .BUD_W(BUD_W), .NW_W(NW_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .load_i(start_ok), .blk_len_i(blk_len_i),
        .budget_o(budget), .nwin_o(nwin), .seg_base_o(seg_base_o)
    );

    tsch_half_timer #(
        .WIN(WIN), .HC_W(HC_W), .BUD_W(BUD_W), .NW_W(NW_W), .WI_W(WI_W)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .run_i(run), .budget_i(budget), .nwin_i(nwin),
        .half_end_o(half_end), .win_start_o(win_start_o), .win_idx_o(win_idx_o)
    );

    tsch_iter_ctrl #(
        .MAX_ITER(MAX_ITER), .IT_W(IT_W), .HF_W(HF_W), .CYC_W(CYC_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_ok_i(start_ok), .lim_i(lim_eff),
        .half_end_i(half_end), .early_stop_i(early_stop_i),
        .run_o(run), .done_o(done_o), .half_o(half_idx_o),
        .iters_o(iters_o), .cyc_o(cycle_cnt_o)
    );

    assign busy_o  = run;
    assign phase_o = half_idx_o[0];

    // R5: window strobes only while a decode runs
    p_strobe_when_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        win_start_o |-> busy_o);

    // R2: a start while busy leaves the segment bases untouched
    p_busy_start_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(seg_base_o));

    // R6: phase flips only at half-iteration boundaries
    p_phase_at_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !half_end) |=> $stable(phase_o));
endmodule

// File: tb/tb_turbo_win_sched.sv
module tb_turbo_win_sched;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [12:0] blk_len_i = '0;
    logic [3:0]  iter_lim_i = '0;
    logic        early_stop_i = 1'b0;
    logic        busy_o, done_o, win_start_o, phase_o;
    logic [51:0] seg_base_o;
    logic [4:0]  win_idx_o;
    logic [3:0]  half_idx_o, iters_o;
    logic [13:0] cycle_cnt_o;

    int n_chk = 0;
    int n_fail = 0;
    bit cmp_en = 1'b0;
    int es_mode = 0;

    // behavioural reference state
    int m_busy, m_done, m_hc, m_half, m_cyc, m_iters, m_S, m_lim;

    always #5 clk = ~clk;

    turbo_win_sched dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .blk_len_i(blk_len_i),
        .iter_lim_i(iter_lim_i), .early_stop_i(early_stop_i),
        .busy_o(busy_o), .done_o(done_o), .seg_base_o(seg_base_o),
        .win_start_o(win_start_o), .win_idx_o(win_idx_o),
        .half_idx_o(half_idx_o), .phase_o(phase_o),
        .iters_o(iters_o), .cycle_cnt_o(cycle_cnt_o)
    );

    function automatic int bud(int s);
        return s / 8 + 64 + 10;
    endfunction

    function automatic int nwins(int s);
        return (s / 4 + 63) / 64;
    endfunction

    function automatic bit len_legal(int s);
        return (s > 0) && (s <= 6144) && (s % 8 == 0);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // reference model, advanced on each clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_hc = 0; m_half = 0;
            m_cyc = 0; m_iters = 0; m_S = 0; m_lim = 1;
        end else begin
            m_done = 0;
            if (m_busy != 0) begin
                m_cyc++;
                if (m_hc == bud(m_S) - 1) begin
                    m_hc = 0;
                    if (m_half % 2 == 1) begin
                        m_iters++;
                        if (early_stop_i || m_iters == m_lim) begin
                            m_busy = 0; m_done = 1; m_half = 0;
                        end else
                            m_half++;
                    end else
                        m_half++;
                end else
                    m_hc++;
            end else if (start_i && len_legal(int'(blk_len_i))) begin
                m_busy = 1; m_S = int'(blk_len_i); m_hc = 0; m_half = 0;
                m_cyc = 0; m_iters = 0;
                m_lim = (iter_lim_i == 0) ? 1 : ((iter_lim_i > 8) ? 8 : int'(iter_lim_i));
            end
        end
    end

    // early-termination stimulus patterns locked to the model state
    always @(negedge clk) begin
        case (es_mode)
            1: early_stop_i = 1'b1;
            2: early_stop_i = (m_busy != 0) && (m_half % 2 == 0);
            3: early_stop_i = (m_busy != 0) && (m_half == 3) && (m_hc == bud(m_S) - 1);
            default: early_stop_i = 1'b0;
        endcase
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_en) begin
            int ews, ewi;
            ews = (m_busy != 0) && (m_hc % 32 == 0) && (m_hc / 32 < nwins(m_S));
            ewi = (m_busy == 0) ? 0 : ((m_hc / 32 >= nwins(m_S)) ? nwins(m_S) - 1 : m_hc / 32);
            chk(busy_o == m_busy, "R2", "busy", busy_o, m_busy);
            chk(done_o == m_done, "R9", "done", done_o, m_done);
            chk(half_idx_o == m_half, "R6", "half index", half_idx_o, m_half);
            chk(phase_o == m_half % 2, "R6", "phase", phase_o, m_half % 2);
            chk(win_start_o == ews, "R5", "window strobe", win_start_o, ews);
            chk(win_idx_o == ewi, "R5", "window index", win_idx_o, ewi);
            chk(cycle_cnt_o == m_cyc, "R10", "cycle count", cycle_cnt_o, m_cyc);
            chk(iters_o == m_iters, "R9", "iterations", iters_o, m_iters);
            for (int k = 0; k < 4; k++)
                chk(seg_base_o[k*13 +: 13] == k * m_S / 4, "R3", "segment base",
                    seg_base_o[k*13 +: 13], k * m_S / 4);
        end
    end

    task automatic start_now(int len, int lim);
        start_i = 1'b1; blk_len_i = 13'(len); iter_lim_i = 4'(lim);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic do_start(int len, int lim);
        @(negedge clk);
        start_now(len, lim);
    endtask

    // wait for the done pulse, then check the iteration and cycle totals
    task automatic wait_done(int len, int exp_it, string req);
        int n = 0;
        while (!done_o && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(done_o == 1'b1, req, "done seen", done_o, 1);
        chk(iters_o == exp_it, req, "iterations at done", iters_o, exp_it);
        chk(cycle_cnt_o == 2 * exp_it * bud(len), "R4", "total cycles",
            cycle_cnt_o, 2 * exp_it * bud(len));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(busy_o == 0 && done_o == 0 && win_start_o == 0 && phase_o == 0, "R1",
            "control outputs", {busy_o, done_o, win_start_o, phase_o}, 0);
        chk(seg_base_o == 0 && win_idx_o == 0 && half_idx_o == 0 && iters_o == 0
            && cycle_cnt_o == 0, "R1", "data outputs", int'(cycle_cnt_o), 0);
        cmp_en = 1'b1;

        // R2: illegal lengths are ignored
        do_start(0, 4);
        chk(busy_o == 0, "R2", "zero length", busy_o, 0);
        do_start(6152, 4);
        chk(busy_o == 0, "R2", "oversize length", busy_o, 0);
        do_start(12, 4);
        chk(busy_o == 0, "R2", "unaligned length", busy_o, 0);

        // largest block, full limit
        es_mode = 0;
        do_start(6144, 8);
        wait_done(6144, 8, "R8");

        // R7: early stop always high ends after one iteration
        es_mode = 1;
        do_start(1000, 8);
        wait_done(1000, 1, "R7");

        // R7: early stop only during even halves is ignored
        es_mode = 2;
        do_start(1000, 5);
        wait_done(1000, 5, "R7");

        // R7: early stop exactly at end of the second iteration
        es_mode = 3;
        do_start(40, 6);
        wait_done(40, 2, "R7");

        // R8: limit 0 acts as 1; R11: start in the done cycle, limit 12 acts as 8
        es_mode = 0;
        do_start(8, 0);
        wait_done(8, 1, "R8");
        start_now(8, 12);
        chk(busy_o == 1, "R11", "start in done cycle", busy_o, 1);
        wait_done(8, 8, "R8");

        // R2: start while busy is ignored
        do_start(2048, 1);
        repeat (5) @(negedge clk);
        start_now(16, 3);
        chk(seg_base_o[13 +: 13] == 512, "R2", "base while busy", seg_base_o[13 +: 13], 512);
        wait_done(2048, 1, "R8");

        repeat (3) @(negedge clk);
        cmp_en = 1'b0;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule